// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands, one bit of the multiplier per clock. It has no per-operation valid/ready handshake. The two operand inputs and a start qualifier are sampled on every clock edge. An idle indication tells the surrounding logic when a new request will be taken.

When a start is seen while the unit is idle, the multiplicand is widened to product width and placed in a left-shifting register. The multiplier goes into a right-shifting register, and the accumulated product is cleared. Each following cycle, the shifted multiplicand is added to the accumulator when the low multiplier bit is set. Then both shift registers move by one place.

The operation ends as soon as the multiplier register holds zero, so short multipliers finish early. The accumulator is presented on the product output at all times. Its value is the final result once the idle indication returns.

Top module: `seqmul_top`

## Requirements
- R1: After reset, `ready_o` is 1 and `product_o` is 0.
- R2: A start sampled while `ready_o` is 1 with a nonzero `op_b_i` makes `ready_o` 0 in the following cycle.
- R3: When `ready_o` returns to 1 after an accepted start, `product_o` equals the unsigned product of the `op_a_i` and `op_b_i` values sampled with that start.
- R4: The number of cycles with `ready_o` at 0 after an accepted start is one more than the bit index of the highest set bit of the accepted `op_b_i`.
- R5: An accepted start with `op_b_i` equal to 0 leaves `ready_o` at 1 in the next cycle, with `product_o` cleared to 0 even if a nonzero result was held before.
- R6: A start asserted while `ready_o` is 0 is ignored: the running operation finishes with its own result and its own cycle count.
- R7: While `ready_o` is 1 and start is 0, `product_o` and `ready_o` stay unchanged whatever the operand inputs do.
- R8: No operation keeps `ready_o` at 0 for more than 16 consecutive cycles (the multiplier width).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a_i | input | 16 | Multiplicand, sampled every cycle |
| op_b_i | input | 16 | Multiplier, sampled every cycle |
| start_i | input | 1 | Start qualifier, sampled every cycle |
| product_o | output | 32 | Accumulated product, driven continuously |
| ready_o | output | 1 | 1 when no operation is running |

## Verification
The hardest situation to bring about is a start request that arrives while an operation is running. For that case the bench must show two things: the second operand pair left no trace, and the first operation kept its cycle count. The bench launches a run whose multiplier has its top bit set, which gives the longest possible run. It then holds start high with different operands for several mid-run cycles and drops start well before completion. Finally it checks the finished product and the number of busy cycles against the first request alone.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;

    // Action selected for the state registers in a cycle
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_STEP = 2'd2
    } seqmul_op_e;

    localparam int unsigned DEF_A_W = 16;
    localparam int unsigned DEF_B_W = 16;

endpackage

// File: rtl/seqmul_step.sv
// One shift-add iteration: conditional accumulate, then shift both operand registers.
module seqmul_step #(
    parameter int unsigned MC_W = 32,
    parameter int unsigned MP_W = 16
) (
    input  logic [MC_W-1:0] mcand_i,
    input  logic [MP_W-1:0] mplr_i,
    input  logic [MC_W-1:0] acc_i,
    output logic [MC_W-1:0] mcand_o,
    output logic [MP_W-1:0] mplr_o,
    output logic [MC_W-1:0] acc_o
);

    logic [MC_W-1:0] addend;

    always_comb begin
        addend  = mplr_i[0] ? mcand_i : '0;
        acc_o   = acc_i + addend;
        mcand_o = {mcand_i[MC_W-2:0], 1'b0};
        mplr_o  = {1'b0, mplr_i[MP_W-1:1]};
    end

endmodule

// File: rtl/seqmul_core.sv
// State registers and sequencing, two-process style.
module seqmul_core
    import seqmul_pkg::*;
#(
    parameter int unsigned A_W = DEF_A_W,
    parameter int unsigned B_W = DEF_B_W,
    parameter int unsigned P_W = A_W + B_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [A_W-1:0] op_a_i,
    input  logic [B_W-1:0] op_b_i,
    input  logic [P_W-1:0] step_mcand_i,
    input  logic [B_W-1:0] step_mplr_i,
    input  logic [P_W-1:0] step_acc_i,
    output logic [P_W-1:0] mcand_q_o,
    output logic [B_W-1:0] mplr_q_o,
    output logic [P_W-1:0] acc_q_o,
    output logic           idle_o
);

    localparam int unsigned PAD_W = P_W - A_W;

    typedef struct packed {
        logic [P_W-1:0] mcand;
        logic [B_W-1:0] mplr;
        logic [P_W-1:0] acc;
    } state_t;

    state_t     state_d;
    state_t     state_q;
    seqmul_op_e op_d;
    logic       idle_d;

    always_comb begin
        state_d = state_q;
        idle_d  = (state_q.mplr == '0);
        if (!idle_d) begin
            op_d = OP_STEP;
        end else if (start_i) begin
            op_d = OP_LOAD;
        end else begin
            op_d = OP_HOLD;
        end
        case (op_d)
            OP_LOAD: begin
                state_d.mcand = {{PAD_W{1'b0}}, op_a_i};
                state_d.mplr  = op_b_i;
                state_d.acc   = '0;
            end
            OP_STEP: begin
                state_d.mcand = step_mcand_i;
                state_d.mplr  = step_mplr_i;
                state_d.acc   = step_acc_i;
            end
            default: begin
                state_d = state_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign mcand_q_o = state_q.mcand;
    assign mplr_q_o  = state_q.mplr;
    assign acc_q_o   = state_q.acc;
    assign idle_o    = idle_d;

endmodule

// File: rtl/seqmul_top.sv
module seqmul_top
    import seqmul_pkg::*;
#(
    parameter int unsigned A_W = DEF_A_W,
    parameter int unsigned B_W = DEF_B_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [A_W-1:0]     op_a_i,
    input  logic [B_W-1:0]     op_b_i,
    input  logic               start_i,
    output logic [A_W+B_W-1:0] product_o,
    output logic               ready_o
);

    localparam int unsigned P_W = A_W + B_W;

    logic [P_W-1:0] mcand_q;
    logic [B_W-1:0] mplr_q;
    logic [P_W-1:0] acc_q;
    logic [P_W-1:0] nxt_mcand;
    logic [B_W-1:0] nxt_mplr;
    logic [P_W-1:0] nxt_acc;
    logic           idle;

    seqmul_step #(
        .MC_W(P_W),
        .MP_W(B_W)
    ) step_i (
        .mcand_i (mcand_q),
        .mplr_i  (mplr_q),
        .acc_i   (acc_q),
        .mcand_o (nxt_mcand),
        .mplr_o  (nxt_mplr),
        .acc_o   (nxt_acc)
    );

    seqmul_core #(
        .A_W(A_W),
        .B_W(B_W),
        .P_W(P_W)
    ) core_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .op_a_i       (op_a_i),
        .op_b_i       (op_b_i),
        .step_mcand_i (nxt_mcand),
        .step_mplr_i  (nxt_mplr),
        .step_acc_i   (nxt_acc),
        .mcand_q_o    (mcand_q),
        .mplr_q_o     (mplr_q),
        .acc_q_o      (acc_q),
        .idle_o       (idle)
    );

    assign product_o = acc_q;
    assign ready_o   = idle;

endmodule

// File: rtl/seqmul_chk.sv
module seqmul_chk #(
    parameter int unsigned A_W = 16,
    parameter int unsigned B_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [A_W-1:0]     op_a_i,
    input logic [B_W-1:0]     op_b_i,
    input logic               start_i,
    input logic [A_W+B_W-1:0] product_o,
    input logic               ready_o
);

    localparam int unsigned P_W = A_W + B_W;
    localparam int unsigned CW  = $clog2(B_W + 2) + 1;
    localparam logic [CW-1:0] LIMIT = CW'(B_W);

    logic [P_W-1:0] exp_q;
    logic [CW-1:0]  busy_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_q      <= '0;
            busy_cnt_q <= '0;
        end else begin
            if (ready_o && start_i) begin
                exp_q <= P_W'(op_a_i) * P_W'(op_b_i);
            end
            if (ready_o) begin
                busy_cnt_q <= '0;
            end else begin
                busy_cnt_q <= busy_cnt_q + 1'b1;
            end
        end
    end

    AST_LOAD_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && start_i && (op_b_i != '0)) |=> !ready_o); // R2

    AST_RESULT_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> (product_o == exp_q)); // R3

    AST_ZERO_MPLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && start_i && (op_b_i == '0)) |=> (ready_o && (product_o == '0))); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !start_i) |=> (ready_o && $stable(product_o))); // R7

    AST_BUSY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt_q <= LIMIT); // R8

endmodule

bind seqmul_top seqmul_chk #(
    .A_W(A_W),
    .B_W(B_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_a_i    (op_a_i),
    .op_b_i    (op_b_i),
    .start_i   (start_i),
    .product_o (product_o),
    .ready_o   (ready_o)
);

// File: tb/seqmul_top_tb_top.sv
`timescale 1ns/1ps
module seqmul_top_tb_top;

    logic        clk;
    logic        rst_n;
    logic [15:0] op_a;
    logic [15:0] op_b;
    logic        start;
    logic [31:0] product;
    logic        ready;

    int n_checks;
    int n_fails;

    seqmul_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_a_i    (op_a),
        .op_b_i    (op_b),
        .start_i   (start),
        .product_o (product),
        .ready_o   (ready)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int busy_len(input logic [15:0] b);
        int n = 0;
        for (int i = 0; i < 16; i++) begin
            if (b[i]) n = i + 1;
        end
        return n;
    endfunction

    task automatic wait_ready();
        int guard = 0;
        while (!ready && guard < 40) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // Issue one accepted request and check R2, R3, R4, R8
    task automatic run_mul(input logic [15:0] a, input logic [15:0] b);
        int cycles = 0;
        logic [31:0] exp = 32'(a) * 32'(b);
        wait_ready();
        op_a  = a;
        op_b  = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op_a  = ~a;
        op_b  = ~b;
        if (b != 16'd0) check(ready == 1'b0, "R2", 32'(ready), 32'd0);
        while (!ready && cycles < 40) begin
            @(negedge clk);
            cycles++;
        end
        check(product == exp, "R3", product, exp);
        check(cycles == busy_len(b), "R4", cycles, busy_len(b));
        check(cycles <= 16, "R8", cycles, 32'd16);
    endtask

    task automatic t_reset();
        check(ready == 1'b1, "R1", 32'(ready), 32'd1);
        check(product == 32'd0, "R1", product, 32'd0);
    endtask

    task automatic t_patterns();
        run_mul(16'd3, 16'd5);
        run_mul(16'hffff, 16'hffff);
        run_mul(16'h1234, 16'h0001);
        run_mul(16'h0000, 16'h00f0);
        run_mul(16'habcd, 16'h8000);
        run_mul(16'h7fff, 16'h0100);
    endtask

    task automatic t_zero_mplr();
        run_mul(16'h00ff, 16'h00ff);
        op_a  = 16'hbeef;
        op_b  = 16'h0000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(ready == 1'b1, "R5", 32'(ready), 32'd1);
        check(product == 32'd0, "R5", product, 32'd0);
    endtask

    task automatic t_busy_start();
        int cycles = 0;
        logic [31:0] exp = 32'h1234 * 32'h8001;
        wait_ready();
        op_a  = 16'h1234;
        op_b  = 16'h8001;
        start = 1'b1;
        @(negedge clk);
        op_a = 16'hffff;
        op_b = 16'h0003;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            cycles++;
        end
        start = 1'b0;
        while (!ready && cycles < 40) begin
            @(negedge clk);
            cycles++;
        end
        check(product == exp, "R6", product, exp);
        check(cycles == 16, "R6", cycles, 32'd16);
    endtask

    task automatic t_hold();
        logic [31:0] held;
        run_mul(16'h0badd, 16'h0031);
        held = product;
        for (int k = 0; k < 6; k++) begin
            op_a = 16'(k * 16'h1357 + 1);
            op_b = 16'(k * 16'h2468 + 7);
            @(negedge clk);
            check(product == held, "R7", product, held);
            check(ready == 1'b1, "R7", 32'(ready), 32'd1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        n_checks = 0;
        n_fails  = 0;
        rst_n = 1'b0;
        op_a  = '0;
        op_b  = '0;
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_patterns();
        t_zero_mplr();
        t_busy_start();
        t_hold();
        run_mul(16'h5555, 16'haaaa);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule